// File: doc/BRIEF.md
# Programmable Test Pattern Generator

This block produces a serial test bit stream from a 32-bit shift register whose contents move from bit 1 (least significant) toward bit 32 (most significant). Bit 1 takes a feedback bit on every enabled cycle, and that feedback bit is also the bit that goes out. The same register serves three purposes. It is a pseudo-random generator with two programmable taps. It is a word repeater of programmable length. It is a quasi-random generator with fixed taps whose output never holds more than thirteen zeros in a row.

Software or a sequencer sets the mode, the two tap positions and a 32-bit seed or pattern word. A load strobe writes the word into the register. After that, each cycle with the bit-enable strobe high produces one pattern bit, and that bit is flagged valid on the next cycle. A lockup guard keeps the random modes running after an all-zero seed.

Control is a two-state machine. `ST_IDLE` is entered at reset; in it no pattern has been loaded and enables are ignored. `ST_RUN` is where bits are produced. Transition `load` goes from `ST_IDLE` to `ST_RUN`. Transition `reload` goes from `ST_RUN` back to `ST_RUN` and rewrites the register. Only reset returns the machine to `ST_IDLE`.

Top module: `tpat_gen`

## Requirements
- R1: After reset, the machine is in ST_IDLE and both bit_o and bit_vld_o are 0.
- R2: In ST_IDLE, bit_en_i has no effect: bit_vld_o stays 0 and bit_o stays 0.
- R3: A cycle with load_i high writes seed_i into the register and enters ST_RUN. Load wins over bit_en_i in the same cycle, so no bit is produced by that cycle (bit_vld_o is 0 on the next cycle).
- R4: In ST_RUN, each cycle with bit_en_i high and load_i low shifts the register one place toward bit 32 and puts the raw feedback bit into bit 1. On the next cycle bit_o carries the output bit and bit_vld_o is 1.
- R5: A cycle in ST_RUN without bit_en_i holds the register. On the next cycle bit_vld_o is 0 and bit_o is unchanged.
- R6: In mode 2'b00, the raw feedback is register bit n XOR register bit y. The tap fields tap_n_i and tap_y_i hold the bit number minus one, so 0 selects bit 1 and 31 selects bit 32.
- R7: In mode 2'b01, the raw feedback is register bit n alone, with no lockup guard. The stream therefore repeats seed bits n, n-1, ..., 1 with period n.
- R8: In mode 2'b10, the raw feedback is bit 17 XOR bit 20 and the tap fields are ignored.
- R9: In modes 2'b00, 2'b10 and 2'b11, the raw feedback is forced to 1 whenever register bits 1 through 31 are all zero, whatever bit 32 holds.
- R10: In mode 2'b10, the output bit is forced to 1 when the raw feedback and register bits 1 through 13 are all zero. The register still receives the raw bit, and the output never shows more than 13 consecutive zeros.
- R11: Mode code 2'b11 behaves exactly as mode 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00 two-tap random, 01 repeat, 10 quasi-random, 11 as 00 |
| tap_n_i | input | 5 | First tap / repeat length, bit number minus one |
| tap_y_i | input | 5 | Second tap, bit number minus one |
| seed_i | input | 32 | Seed or pattern word written on load |
| load_i | input | 1 | Write seed_i into the register and start generation |
| bit_en_i | input | 1 | Produce one pattern bit this cycle |
| bit_o | output | 1 | Last produced pattern bit |
| bit_vld_o | output | 1 | bit_o was produced on the previous cycle |

## Verification
The two-tap mode is swept over every pairing of the two tap positions, each with its own seed. This separates tap decoding errors, swapped taps and off-by-one bit numbering. The repeat mode is run at every length from 1 to 32, and each output is compared arithmetically against the seed bit it must reproduce; a wrong shift direction or an active lockup guard shows up here. The quasi-random mode starts from a sparse seed whose early raw run is long enough to trigger suppression, which separates forcing the output from forcing the register. All-zero and top-bit-only seeds exercise the lockup guard, and interleaved idle, hold and simultaneous load-and-enable cycles exercise the control paths.

// File: rtl/tpat_pkg.sv
package tpat_pkg;

    typedef enum logic [1:0] {
        PM_PRBS     = 2'b00,
        PM_REPEAT   = 2'b01,
        PM_QRSS     = 2'b10,
        PM_PRBS_ALT = 2'b11
    } pmode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } gstate_e;

    // Fixed quasi-random taps, numbered from 1
    localparam int QR_TAP_A = 17;
    localparam int QR_TAP_B = 20;

endpackage

// File: rtl/tpat_fb.sv
module tpat_fb
    import tpat_pkg::*;
#(
    parameter int W  = 32,
    parameter int TW = $clog2(W)
) (
    input  logic [W-1:0]  shreg_i,
    input  pmode_e        mode_i,
    input  logic [TW-1:0] tap_n_i,
    input  logic [TW-1:0] tap_y_i,
    output logic          raw_fb_o
);

    logic sel_n;
    logic sel_y;
    logic qr_fb;
    logic low_zero;

    always_comb begin
        sel_n    = shreg_i[tap_n_i];
        sel_y    = shreg_i[tap_y_i];
        qr_fb    = shreg_i[QR_TAP_A-1] ^ shreg_i[QR_TAP_B-1];
        low_zero = ~|shreg_i[W-2:0];
    end

    always_comb begin
        unique case (mode_i)
            PM_REPEAT: raw_fb_o = sel_n;
            PM_QRSS:   raw_fb_o = qr_fb | low_zero;
            default:   raw_fb_o = (sel_n ^ sel_y) | low_zero;
        endcase
    end

endmodule

// File: rtl/tpat_zrun.sv
module tpat_zrun #(
    parameter int W   = 32,
    parameter int RUN = 14
) (
    input  logic [W-1:0] shreg_i,
    input  logic         raw_fb_i,
    input  logic         active_i,
    output logic         out_bit_o
);

    logic hist_zero;

    generate
        if (RUN > 1) begin : g_hist
            assign hist_zero = ~|shreg_i[RUN-2:0];
        end else begin : g_nohist
            assign hist_zero = 1'b1;
        end
    endgenerate

    assign out_bit_o = raw_fb_i | (active_i & hist_zero);

endmodule

// File: rtl/tpat_gen.sv
module tpat_gen
    import tpat_pkg::*;
#(
    parameter int W    = 32,
    parameter int RUN  = 14,
    parameter int TW   = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic [TW-1:0] tap_n_i,
    input  logic [TW-1:0] tap_y_i,
    input  logic [W-1:0]  seed_i,
    input  logic          load_i,
    input  logic          bit_en_i,
    output logic          bit_o,
    output logic          bit_vld_o
);

    localparam int CW = $clog2(RUN + 1) + 1;

    gstate_e       state_q;
    gstate_e       state_d;
    logic [W-1:0]  shreg_q;
    pmode_e        mode;
    logic          raw_fb;
    logic          out_bit;
    logic          do_shift;

    assign mode     = pmode_e'(mode_i);
    assign do_shift = (state_q == ST_RUN) && bit_en_i && !load_i;

    tpat_fb #(.W(W), .TW(TW)) u_fb (
        .shreg_i  (shreg_q),
        .mode_i   (mode),
        .tap_n_i  (tap_n_i),
        .tap_y_i  (tap_y_i),
        .raw_fb_o (raw_fb)
    );

    tpat_zrun #(.W(W), .RUN(RUN)) u_zrun (
        .shreg_i   (shreg_q),
        .raw_fb_i  (raw_fb),
        .active_i  (mode == PM_QRSS),
        .out_bit_o (out_bit)
    );

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load_i) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            bit_o     <= 1'b0;
            bit_vld_o <= 1'b0;
        end else begin
            bit_vld_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (load_i) shreg_q <= seed_i;
                end
                ST_RUN: begin
                    if (load_i) begin
                        shreg_q <= seed_i;
                    end else if (bit_en_i) begin
                        shreg_q   <= {shreg_q[W-2:0], raw_fb};
                        bit_o     <= out_bit;
                        bit_vld_o <= 1'b1;
                    end
                end
                default: shreg_q <= shreg_q;
            endcase
        end
    end

    // Zero-run observer for the quasi-random check
    logic [CW-1:0] zcnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       zcnt_q <= '0;
        else if (load_i || mode != PM_QRSS) zcnt_q <= '0;
        else if (do_shift)                zcnt_q <= out_bit ? '0 : zcnt_q + 1'b1;
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!bit_vld_o && !bit_o));

    a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (!bit_vld_o && shreg_q == $past(seed_i) && state_q == ST_RUN));

    a_r4_shift: assert property (@(posedge clk) disable iff (!rst_n)
        do_shift |=> (bit_vld_o && shreg_q[W-1:1] == $past(shreg_q[W-2:0])));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !bit_en_i) |=> (!bit_vld_o && $stable(shreg_q) && $stable(bit_o)));

    a_r9_lockup: assert property (@(posedge clk) disable iff (!rst_n)
        (do_shift && mode != PM_REPEAT && shreg_q[W-2:0] == '0) |=> (bit_o && shreg_q[0]));

    a_r10_zero_run: assert property (@(posedge clk) disable iff (!rst_n)
        zcnt_q <= CW'(RUN - 1));

endmodule

// File: tb/tb_tpat_gen.sv
module tb_tpat_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [4:0]  tap_n_i = '0;
    logic [4:0]  tap_y_i = '0;
    logic [31:0] seed_i = '0;
    logic        load_i = 1'b0;
    logic        bit_en_i = 1'b0;
    logic        bit_o;
    logic        bit_vld_o;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] mr;

    always #5 clk = ~clk;

    tpat_gen dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .tap_n_i(tap_n_i),
        .tap_y_i(tap_y_i), .seed_i(seed_i), .load_i(load_i),
        .bit_en_i(bit_en_i), .bit_o(bit_o), .bit_vld_o(bit_vld_o)
    );

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Raw feedback from the requirement text; n and y are 1-based
    function automatic logic raw_of(logic [31:0] r, int md, int n, int y);
        logic f;
        if (md == 1) return r[n-1];
        if (md == 2) f = r[16] ^ r[19];
        else         f = r[n-1] ^ r[y-1];
        if (r[30:0] == 0) f = 1'b1;
        return f;
    endfunction

    function automatic logic out_of(logic [31:0] r, int md, logic raw);
        if (md == 2 && raw == 1'b0 && r[12:0] == 0) return 1'b1;
        return raw;
    endfunction

    task automatic step(output logic b, output logic v);
        bit_en_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        b = bit_o;
        v = bit_vld_o;
        bit_en_i = 1'b0;
    endtask

    task automatic do_load(input int md, input int n, input int y, input logic [31:0] s);
        mode_i = md[1:0];
        tap_n_i = 5'(n - 1);
        tap_y_i = 5'(y - 1);
        seed_i = s;
        load_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        load_i = 1'b0;
        mr = s;
    endtask

    // Step once and compare with the model; returns 1 on match
    task automatic model_step(input int md, input int n, input int y,
                              output bit ok, output logic a, output logic e);
        logic b, v, raw;
        raw = raw_of(mr, md, n, y);
        e = out_of(mr, md, raw);
        mr = {mr[30:0], raw};
        step(b, v);
        a = b;
        ok = (b === e) && (v === 1'b1);
    endtask

    task automatic run_seq(input int md, input int n, input int y, input logic [31:0] s,
                           input int len, input string req);
        bit ok, all_ok;
        logic a, e;
        logic [31:0] fa, fe;
        all_ok = 1'b1; fa = '0; fe = '0;
        do_load(md, n, y, s);
        for (int k = 0; k < len; k++) begin
            model_step(md, n, y, ok, a, e);
            if (!ok && all_ok) begin
                all_ok = 1'b0; fa = {31'd0, a}; fe = {31'd0, e};
            end
        end
        chk(all_ok, req, fa, fe);
    endtask

    initial begin
        logic b, v;
        bit ok, all_ok;
        logic a, e;
        int zrun, zmax, forced;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(bit_o === 1'b0 && bit_vld_o === 1'b0, "R1 reset outputs", {bit_o, bit_vld_o}, 0);

        // R2 enable ignored before any load
        for (int k = 0; k < 3; k++) begin
            step(b, v);
            chk(v === 1'b0 && b === 1'b0, "R2 idle enable ignored", {b, v}, 0);
        end

        // R3 load and enable together: load wins
        mode_i = 2'b00; tap_n_i = 5'd6; tap_y_i = 5'd5; seed_i = 32'h0000_0041;
        load_i = 1'b1; bit_en_i = 1'b1;
        @(posedge clk); @(negedge clk);
        load_i = 1'b0; bit_en_i = 1'b0;
        mr = 32'h0000_0041;
        chk(bit_vld_o === 1'b0, "R3 load priority no bit", bit_vld_o, 0);
        model_step(0, 7, 6, ok, a, e);
        chk(ok, "R3 first bit from seed", a, e);

        // R5 hold: no enable, no valid, output stable, register kept
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); @(negedge clk);
            chk(bit_vld_o === 1'b0 && bit_o === a, "R5 hold", {bit_o, bit_vld_o}, {a, 1'b0});
        end
        all_ok = 1'b1;
        for (int k = 0; k < 20; k++) begin
            model_step(0, 7, 6, ok, a, e);
            if (!ok) all_ok = 1'b0;
        end
        chk(all_ok, "R5 resume after hold / R4", a, e);

        // R6 and R4: every tap pairing
        for (int n = 1; n <= 32; n++)
            for (int y = 1; y <= 32; y++)
                run_seq(0, n, y, 32'h9E37_79B9 ^ (n * 32'h0101_1F3D) ^ (y * 32'h0007_A5C1), 36,
                        "R6 two-tap sequence");

        // R11 code 3 same as two-tap mode
        run_seq(3, 23, 18, 32'h1234_5678, 200, "R11 alternate code");

        // R7 repeat: arithmetic expectation from seed bits
        for (int n = 1; n <= 32; n++) begin
            logic [31:0] s;
            s = 32'hC3A5_0F96 ^ (n * 32'h0F1E_2D3C);
            do_load(1, n, 1, s);
            all_ok = 1'b1; a = 0; e = 0;
            for (int k = 0; k < 2 * n + 3; k++) begin
                logic ex;
                ex = s[n - 1 - (k % n)];
                step(b, v);
                if ((b !== ex || v !== 1'b1) && all_ok) begin
                    all_ok = 1'b0; a = b; e = ex;
                end
            end
            chk(all_ok, "R7 repeat period", a, e);
        end
        // R7 repeat with all-zero word: no lockup guard
        do_load(1, 8, 1, 32'h0);
        all_ok = 1'b1;
        for (int k = 0; k < 10; k++) begin
            step(b, v);
            if (b !== 1'b0) all_ok = 1'b0;
        end
        chk(all_ok, "R7 repeat zeros stay zero", b, 0);

        // R9 lockup guard
        run_seq(0, 5, 3, 32'h0, 40, "R9 zero seed two-tap");
        run_seq(0, 32, 32, 32'h8000_0000, 40, "R9 top bit only");
        do_load(2, 1, 1, 32'h0);
        step(b, v);
        chk(b === 1'b1, "R9 zero seed quasi-random", b, 1);

        // R8 and R10 quasi-random with suppression; taps set oddly to show they are ignored
        do_load(2, 3, 9, 32'h0000_0001);
        all_ok = 1'b1; zrun = 0; zmax = 0; forced = 0; a = 0; e = 0;
        for (int k = 0; k < 3000; k++) begin
            logic raw;
            raw = raw_of(mr, 2, 3, 9);
            if (out_of(mr, 2, raw) != raw) forced++;
            model_step(2, 3, 9, ok, a, e);
            if (!ok) all_ok = 1'b0;
            zrun = (a === 1'b0) ? zrun + 1 : 0;
            if (zrun > zmax) zmax = zrun;
        end
        chk(all_ok, "R8 quasi-random sequence", a, e);
        chk(forced > 0, "R10 suppression exercised", forced, 1);
        chk(zmax <= 13, "R10 zero run limit", zmax, 13);

        // R3 reload mid-run restarts from new seed
        run_seq(0, 17, 14, 32'h0BAD_F00D, 50, "R3 reload in run");

        finish_run();
    end

endmodule